// File: doc/BRIEF.md
# Error-Correction Command Sequencer with Sticky Abort

This block sequences the error-correction engine of an optical-disc sector buffer. A microcontroller writes a 4-bit command code, qualified by a one-cycle valid strobe. The sequencer runs one multi-step operation at a time. It writes the fixed sync pattern into the sector buffer itself. It starts stub sub-engines for syndrome arithmetic, CRC recalculation, buffer-to-ECC-RAM copies and correction or test work, and keeps the four zero-flag status bits that the microcontroller reads. Each sub-engine gets a one-cycle start pulse, and the sequencer waits for that engine's done pulse before it moves on.

The sequencer wakes up in a sticky abort state. The abort code is honoured in any state and at any time. Only the release code leaves the abort state. The state machine has these states: ABORT (held after reset or an abort), IDLE (ready), HDR (copy the sector header, mode 2 form 1 only), FILL (write the sync pattern, one byte per cycle), SYN (syndrome pass), FLAGS (copy the error flags), CREM (copy the CRC remainder, then commit the status), CRC (recalculate the CRC), RES (copy the results) and AUX (correction and test commands). The transitions are as follows. ABORT goes to IDLE on release. IDLE goes to HDR or FILL on a syndrome command, to CRC, RES or AUX on those commands, and stays on any other code. The syndrome pass runs HDR, then FILL when the header copy is done, then SYN when the last pattern byte is written, then FLAGS on syndrome done, then CREM on copy done. CREM, CRC, RES and AUX return to IDLE on the done of their engine. Any state goes to ABORT on the abort code.

Top module: `ecc_seq`

## Requirements
- R1: Command codes decode as follows. 0000 is abort and 0001 is release. 0010/0011 are syndrome, 0100/0101 are CRC and 0110/0111 are result copy; in each pair the odd code selects mode 2 form 1. 1000, 1001, 1100, 1101 and 1110 are auxiliary commands.
- R2: After reset the block is in the abort state: `aborted`=1, `busy`=0 and no buffer write or engine start.
- R3: In the abort state all four status bits read 0, and every code except 0001 is ignored. Code 0001 returns the block to idle.
- R4: Code 0000 is taken in any state. From the next cycle on, there is no buffer write and no engine start, and `aborted`=1.
- R5: A syndrome command in other modes writes one byte per cycle to addresses 0..11 and then 2068..2075, in ascending order. Addresses 1..10 get 0xFF and all others get 0x00.
- R6: A syndrome command in mode 2 form 1 first copies the header (`copy_sel`=0). It then writes addresses 0..15 in ascending order, with 0xFF at 1..10 and 0x00 elsewhere.
- R7: After the pattern writes, the syndrome pass starts the syndrome engine, then the flags copy (`copy_sel`=1), then the CRC-remainder copy (`copy_sel`=2). Each step gets one start pulse and waits for its done pulse.
- R8: `ps_eq0`/`qs_eq0` take the syndrome engine's zero flags, and `flags_eq0` takes `copy_zero` from the flags copy. All three change only when the whole syndrome operation ends.
- R9: A CRC command starts the CRC engine with `sec_m21` set to the command's mode, and loads `crc_eq0` from `crc_zero` on done.
- R10: `busy` is 1 from command acceptance to completion. A non-abort command written while busy is ignored.
- R11: Codes 1010, 1011 and 1111 do nothing: `busy` stays 0 and no status bit changes.
- R12: Result copy starts a copy with `copy_sel`=3. Auxiliary commands start the auxiliary engine with `aux_op` equal to the code. Neither changes any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 4 | Command code |
| busy | output | 1 | Operation in progress |
| aborted | output | 1 | Sticky abort state |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | ADDR_W | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| sec_m21 | output | 1 | Mode of the current command (1 = mode 2 form 1) |
| syn_start | output | 1 | Syndrome engine start pulse |
| syn_done | input | 1 | Syndrome engine done |
| syn_ps_zero | input | 1 | All P syndromes zero, valid with done |
| syn_qs_zero | input | 1 | All Q syndromes zero, valid with done |
| copy_start | output | 1 | Copy engine start pulse |
| copy_sel | output | 2 | Copy kind: 0 header, 1 flags, 2 CRC remainder, 3 results |
| copy_done | input | 1 | Copy engine done |
| copy_zero | input | 1 | Copied data all zero, valid with done |
| crc_start | output | 1 | CRC engine start pulse |
| crc_done | input | 1 | CRC engine done |
| crc_zero | input | 1 | CRC remainder zero, valid with done |
| aux_start | output | 1 | Auxiliary engine start pulse |
| aux_op | output | 4 | Auxiliary command code |
| aux_done | input | 1 | Auxiliary engine done |
| ps_eq0 | output | 1 | P syndromes zero status |
| qs_eq0 | output | 1 | Q syndromes zero status |
| flags_eq0 | output | 1 | Error flags zero status |
| crc_eq0 | output | 1 | CRC remainder zero status |

## Verification
Several properties are checked on every cycle:
- the status bits stay cleared throughout the abort state;
- an abort code silences buffer writes and engine starts on the next cycle;
- at most one engine start is active at a time;
- the zero-flag bits move only at the end of an operation or on abort;
- the unassigned codes leave the block idle;
- pattern writes stay inside the sector.

Other behaviour can only be shown by the bench's scenarios, which compare against a scoreboard of expected writes and a log of engine starts:
- the exact address and data order of the pattern in both sector modes;
- the step order of the syndrome pass;
- which values reach the status bits;
- that commands are dropped while busy;
- that a mid-fill abort cuts the write stream after a known count.

// File: rtl/ecc_seq_pkg.sv
package ecc_seq_pkg;

    localparam logic [3:0] CMD_ABORT   = 4'b0000;
    localparam logic [3:0] CMD_RELEASE = 4'b0001;

    localparam logic [1:0] COPY_HDR  = 2'd0;
    localparam logic [1:0] COPY_FLG  = 2'd1;
    localparam logic [1:0] COPY_CREM = 2'd2;
    localparam logic [1:0] COPY_RES  = 2'd3;

    typedef enum logic [2:0] {
        K_NOP, K_ABORT, K_RELEASE, K_SYN, K_CRC, K_COPY, K_AUX
    } kind_e;

    typedef enum logic [3:0] {
        S_ABORT, S_IDLE, S_HDR, S_FILL, S_SYN,
        S_FLAGS, S_CREM, S_CRC, S_RES, S_AUX
    } state_e;

endpackage

// File: rtl/ecc_seq_decode.sv
module ecc_seq_decode
    import ecc_seq_pkg::*;
(
    input  logic [3:0] code,
    output kind_e      kind,
    output logic       m21
);

    always_comb begin
        unique case (code)
            4'b0000:                            kind = K_ABORT;
            4'b0001:                            kind = K_RELEASE;
            4'b0010, 4'b0011:                   kind = K_SYN;
            4'b0100, 4'b0101:                   kind = K_CRC;
            4'b0110, 4'b0111:                   kind = K_COPY;
            4'b1000, 4'b1001, 4'b1100,
            4'b1101, 4'b1110:                   kind = K_AUX;
            default:                            kind = K_NOP;
        endcase
        // odd code of each mode-dependent pair selects mode 2 form 1 (R1)
        m21 = code[0] && (code[3:1] inside {3'd1, 3'd2, 3'd3});
    end

endmodule

// File: rtl/ecc_seq_fill.sv
module ecc_seq_fill #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int SYNC_FIRST = 1,
    parameter int SYNC_LAST  = 10,
    parameter int HEAD_LAST  = 11,
    parameter int M21_LAST   = 15,
    parameter int TAIL_FIRST = 2068,
    parameter int SECT_LAST  = 2075
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              m21,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              last
);

    localparam logic [ADDR_W-1:0] A_HEAD = ADDR_W'(HEAD_LAST);
    localparam logic [ADDR_W-1:0] A_TAIL = ADDR_W'(TAIL_FIRST);
    localparam logic [ADDR_W-1:0] A_M21  = ADDR_W'(M21_LAST);
    localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(SECT_LAST);
    localparam logic [ADDR_W-1:0] A_S0   = ADDR_W'(SYNC_FIRST);
    localparam logic [ADDR_W-1:0] A_S1   = ADDR_W'(SYNC_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (!run) begin
            addr <= '0;
        end else if (!m21 && addr == A_HEAD) begin
            addr <= A_TAIL;
        end else begin
            addr <= addr + 1'b1;
        end
    end

    always_comb begin
        data = (addr >= A_S0 && addr <= A_S1) ? {DATA_W{1'b1}} : '0;
        last = m21 ? (addr == A_M21) : (addr == A_END);
    end

    p_fill_in_sector_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (m21 ? addr <= A_M21 : (addr <= A_HEAD || (addr >= A_TAIL && addr <= A_END))));

    p_fill_skip_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !m21 && addr == A_HEAD) |=> (!run || addr == A_TAIL));

endmodule

// File: rtl/ecc_seq.sv
module ecc_seq
    import ecc_seq_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int TAIL_FIRST = 2068,
    parameter int SECT_LAST  = 2075
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd,
    output logic              busy,
    output logic              aborted,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              sec_m21,
    output logic              syn_start,
    input  logic              syn_done,
    input  logic              syn_ps_zero,
    input  logic              syn_qs_zero,
    output logic              copy_start,
    output logic [1:0]        copy_sel,
    input  logic              copy_done,
    input  logic              copy_zero,
    output logic              crc_start,
    input  logic              crc_done,
    input  logic              crc_zero,
    output logic              aux_start,
    output logic [3:0]        aux_op,
    input  logic              aux_done,
    output logic              ps_eq0,
    output logic              qs_eq0,
    output logic              flags_eq0,
    output logic              crc_eq0
);

    state_e state_q, nxt;
    logic   kick_q;
    logic   m21_q;
    logic [3:0] op_q;
    logic   ps_l, qs_l, fl_l;
    kind_e  kind;
    logic   dm21;
    logic   fill_last;
    logic   abort_req;

    ecc_seq_decode u_dec (
        .code (cmd),
        .kind (kind),
        .m21  (dm21)
    );

    ecc_seq_fill #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (8),
        .TAIL_FIRST (TAIL_FIRST),
        .SECT_LAST  (SECT_LAST)
    ) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == S_FILL),
        .m21   (m21_q),
        .addr  (buf_addr),
        .data  (buf_wdata),
        .last  (fill_last)
    );

    assign abort_req = cmd_valid && kind == K_ABORT;

    // next-state logic
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            S_ABORT: if (cmd_valid && kind == K_RELEASE) nxt = S_IDLE;
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (kind)
                        K_SYN:   nxt = dm21 ? S_HDR : S_FILL;
                        K_CRC:   nxt = S_CRC;
                        K_COPY:  nxt = S_RES;
                        K_AUX:   nxt = S_AUX;
                        default: nxt = S_IDLE;
                    endcase
                end
            end
            S_HDR:   if (!kick_q && copy_done) nxt = S_FILL;
            S_FILL:  if (fill_last)            nxt = S_SYN;
            S_SYN:   if (!kick_q && syn_done)  nxt = S_FLAGS;
            S_FLAGS: if (!kick_q && copy_done) nxt = S_CREM;
            S_CREM:  if (!kick_q && copy_done) nxt = S_IDLE;
            S_CRC:   if (!kick_q && crc_done)  nxt = S_IDLE;
            S_RES:   if (!kick_q && copy_done) nxt = S_IDLE;
            S_AUX:   if (!kick_q && aux_done)  nxt = S_IDLE;
            default: nxt = S_ABORT;
        endcase
        if (abort_req) nxt = S_ABORT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_ABORT;
            kick_q  <= 1'b0;
        end else begin
            state_q <= nxt;
            kick_q  <= (nxt != state_q);
        end
    end

    // command context and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m21_q <= 1'b0; op_q <= '0;
            ps_l <= 1'b0; qs_l <= 1'b0; fl_l <= 1'b0;
            ps_eq0 <= 1'b0; qs_eq0 <= 1'b0; flags_eq0 <= 1'b0; crc_eq0 <= 1'b0;
        end else if (abort_req || state_q == S_ABORT) begin
            ps_eq0 <= 1'b0; qs_eq0 <= 1'b0; flags_eq0 <= 1'b0; crc_eq0 <= 1'b0;
        end else begin
            if (state_q == S_IDLE && nxt != S_IDLE) begin
                m21_q <= dm21;
                op_q  <= cmd;
            end
            if (state_q == S_SYN && !kick_q && syn_done) begin
                ps_l <= syn_ps_zero;
                qs_l <= syn_qs_zero;
            end
            if (state_q == S_FLAGS && !kick_q && copy_done) fl_l <= copy_zero;
            if (state_q == S_CREM && !kick_q && copy_done) begin
                ps_eq0    <= ps_l;
                qs_eq0    <= qs_l;
                flags_eq0 <= fl_l;
            end
            if (state_q == S_CRC && !kick_q && crc_done) crc_eq0 <= crc_zero;
        end
    end

    // outputs
    always_comb begin
        busy       = !(state_q inside {S_ABORT, S_IDLE});
        aborted    = (state_q == S_ABORT);
        buf_we     = (state_q == S_FILL);
        sec_m21    = m21_q;
        aux_op     = op_q;
        syn_start  = kick_q && state_q == S_SYN;
        crc_start  = kick_q && state_q == S_CRC;
        aux_start  = kick_q && state_q == S_AUX;
        copy_start = kick_q && (state_q inside {S_HDR, S_FLAGS, S_CREM, S_RES});
        unique case (state_q)
            S_FLAGS: copy_sel = COPY_FLG;
            S_CREM:  copy_sel = COPY_CREM;
            S_RES:   copy_sel = COPY_RES;
            default: copy_sel = COPY_HDR;
        endcase
    end

    p_abort_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |-> !(ps_eq0 || qs_eq0 || flags_eq0 || crc_eq0));

    p_abort_silences_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == CMD_ABORT) |=>
        (aborted && !buf_we && !syn_start && !crc_start && !copy_start && !aux_start));

    p_single_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({syn_start, crc_start, copy_start, aux_start}));

    p_status_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ps_eq0, qs_eq0, flags_eq0}) |-> ($fell(busy) || aborted));

    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && cmd != CMD_ABORT) |=> $stable(aux_op));

    p_nop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !aborted && cmd_valid && cmd inside {4'b1010, 4'b1011, 4'b1111})
        |=> (!busy && $stable({ps_eq0, qs_eq0, flags_eq0, crc_eq0})));

endmodule

// File: tb/ecc_seq_bench.sv
module ecc_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0;
    logic [3:0] cmd = 0;
    logic busy, aborted, buf_we, sec_m21;
    logic [11:0] buf_addr;
    logic [7:0] buf_wdata;
    logic syn_start, copy_start, crc_start, aux_start;
    logic syn_done = 0, copy_done = 0, crc_done = 0, aux_done = 0;
    logic syn_ps_zero = 0, syn_qs_zero = 0, copy_zero = 0, crc_zero = 0;
    logic [1:0] copy_sel;
    logic [3:0] aux_op;
    logic ps_eq0, qs_eq0, flags_eq0, crc_eq0;

    int nchk = 0, nfail = 0;
    int cnt[4] = '{0, 0, 0, 0};
    int ev[$];
    int exp_q[$];
    logic crc_mode_seen = 0;
    logic finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_seq u_ecc_seq (.*);

    task automatic chk(input string tag, input logic ok, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int status();
        return {28'd0, ps_eq0, qs_eq0, flags_eq0, crc_eq0};
    endfunction

    // stub engines: log each start, answer with done some cycles later
    always @(negedge clk) begin
        syn_done = 0; crc_done = 0; copy_done = 0; aux_done = 0;
        for (int i = 0; i < 4; i++) begin
            if (cnt[i] > 0) begin
                cnt[i]--;
                if (cnt[i] == 0) begin
                    if (i == 0) syn_done = 1;
                    if (i == 1) crc_done = 1;
                    if (i == 2) copy_done = 1;
                    if (i == 3) aux_done = 1;
                end
            end
        end
        if (syn_start)  begin cnt[0] = 3; ev.push_back(8); end
        if (crc_start)  begin cnt[1] = 4; ev.push_back(9); crc_mode_seen = sec_m21; end
        if (copy_start) begin cnt[2] = 2; ev.push_back(int'(copy_sel)); end
        if (aux_start)  begin cnt[3] = 2; ev.push_back(16 + int'(aux_op)); end
    end

    // scoreboard monitor for buffer writes (R5 R6 R4)
    always @(negedge clk) begin
        if (rst_n && buf_we) begin
            if (exp_q.size() == 0) begin
                chk("R4/R5 unexpected buffer write", 0, int'(buf_addr), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk("R5/R6 write addr/data", {buf_addr, buf_wdata} == e[19:0],
                    int'({buf_addr, buf_wdata}), e);
            end
        end
    end

    task automatic push_fill(input logic m21, input int n);
        int k = 0;
        for (int a = 0; a <= 2075; a++) begin
            logic inr;
            inr = m21 ? (a <= 15) : (a <= 11 || a >= 2068);
            if (inr && (n < 0 || k < n)) begin
                exp_q.push_back((a << 8) | ((a >= 1 && a <= 10) ? 8'hFF : 8'h00));
                k++;
            end
        end
    endtask

    task automatic send(input logic [3:0] c);
        @(negedge clk); cmd_valid = 1; cmd = c;
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic wait_idle(input string tag, input int st0);
        logic ok = 1;
        for (int i = 0; i < 300 && busy; i++) begin
            @(negedge clk);
            if (busy && status()[3:1] != st0[3:1]) ok = 0;
        end
        chk({tag, " status held while busy"}, ok, status(), st0);
        repeat (6) @(negedge clk);
    endtask

    task automatic chk_log(input string tag, input int e[$]);
        logic ok;
        ok = (ev.size() == e.size());
        if (ok) foreach (e[i]) if (ev[i] != e[i]) ok = 0;
        chk(tag, ok, ev.size() > 0 ? ev[0] : -1, e.size() > 0 ? e[0] : -1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2 reset state
        chk("R2 aborted after reset", aborted === 1, aborted, 1);
        chk("R2 idle after reset", busy === 0 && buf_we === 0, busy, 0);
        // R3 commands ignored while aborted
        send(4'b0010); repeat (3) @(negedge clk);
        chk("R3 command ignored in abort", busy == 0 && aborted == 1 && ev.size() == 0, busy, 0);
        chk("R3 status cleared in abort", status() == 0, status(), 0);
        send(4'b0001);
        chk("R3 release leaves abort", aborted == 0 && busy == 0, aborted, 0);

        // R5 R7 R8 syndrome, other modes
        syn_ps_zero = 1; syn_qs_zero = 0; copy_zero = 1;
        ev.delete(); push_fill(0, -1);
        send(4'b0010);
        chk("R10 busy after accept", busy == 1, busy, 1);
        wait_idle("R8", 0);
        chk("R8 status after syndrome", status() == 4'b1010, status(), 4'b1010);
        chk("R5 all writes seen", exp_q.size() == 0, exp_q.size(), 0);
        chk_log("R1/R7 step order", '{8, 1, 2});

        // R6 mode 2 form 1
        syn_ps_zero = 0; syn_qs_zero = 1; copy_zero = 0;
        ev.delete(); push_fill(1, -1);
        send(4'b0011);
        wait_idle("R8", 4'b1010);
        chk("R8 status after m21 syndrome", status() == 4'b0100, status(), 4'b0100);
        chk("R6 all writes seen", exp_q.size() == 0, exp_q.size(), 0);
        chk_log("R6 header copy first", '{0, 8, 1, 2});

        // R9 R10 CRC m21, syndrome command while busy is dropped
        crc_zero = 1; ev.delete();
        send(4'b0101);
        send(4'b0010);
        wait_idle("R10", 4'b0100);
        chk("R9 crc status", crc_eq0 == 1, crc_eq0, 1);
        chk("R9 crc mode", crc_mode_seen == 1, crc_mode_seen, 1);
        chk_log("R10 busy command ignored", '{9});
        chk("R10 status kept", status() == 4'b0101, status(), 4'b0101);

        crc_zero = 0; ev.delete();
        send(4'b0100);
        wait_idle("R9", 4'b0101);
        chk("R9 crc other mode", crc_eq0 == 0 && crc_mode_seen == 0, crc_eq0, 0);

        // R11 no-op codes
        ev.delete();
        send(4'b1010);
        chk("R11 1010 not busy", busy == 0, busy, 0);
        send(4'b1111);
        repeat (5) @(negedge clk);
        chk("R11 no start no status", ev.size() == 0 && status() == 4'b0100, status(), 4'b0100);

        // R12 result copy and auxiliary
        ev.delete();
        send(4'b0111);
        wait_idle("R12", 4'b0100);
        chk_log("R1/R12 result copy", '{3});
        ev.delete();
        send(4'b1101);
        wait_idle("R12", 4'b0100);
        chk_log("R1/R12 aux op", '{29});
        chk("R12 status unchanged", status() == 4'b0100, status(), 4'b0100);

        // R4 abort mid-fill: five writes then silence
        push_fill(0, 5);
        send(4'b0010);
        repeat (3) @(negedge clk);
        send(4'b0000);
        ev.delete();
        chk("R4 aborted", aborted == 1 && busy == 0, aborted, 1);
        chk("R3 status cleared by abort", status() == 0, status(), 0);
        repeat (30) @(negedge clk);
        chk("R4 no writes after abort", exp_q.size() == 0, exp_q.size(), 0);
        chk("R4 no starts after abort", ev.size() == 0, ev.size(), 0);

        // R4 abort while waiting on an engine; late done ignored
        send(4'b0001);
        crc_zero = 1;
        send(4'b0100);
        send(4'b0000);
        repeat (10) @(negedge clk);
        chk("R4 late done ignored", aborted == 1 && crc_eq0 == 0, crc_eq0, 0);
        send(4'b0001);
        chk("R3 release to idle", busy == 0 && aborted == 0, busy, 0);

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule